// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Front End

This block is the synchronous front end of a flow-through static RAM whose bus never needs an idle cycle between reads and writes. On every enabled rising edge it takes in a command, an address and per-byte write enables. Three chip selects gate new operations. An advance input steps a two-bit burst counter that supplies the two low address bits, in either interleaved or linear order. A write's data arrives one cycle after its address. The data is held with its address in a dedicated write register and is committed to the array on the following enabled edge. Reads of a word still waiting in that register are served by a per-lane bypass.

Read data passes from the array to `rdata_o` through no output register. The output is qualified by `drive_o`, which the pad ring uses as the tri-state enable. An asynchronous output enable and an asynchronous sleep input both clear `drive_o` at once. A low clock enable suspends the whole block. Sleep also freezes every register and blocks all array writes, so a burst picks up where it stopped once sleep is released.

Top module: `nt_sram_fe`

## Requirements
- R1: After reset no operation is active, `drive_o` is 0 and `rdata_o` is all zeros.
- R2: A new operation starts at an enabled edge only when `sel_a_i`=1, `sel_b_i`=1, `sel_n_i`=0 and `adv_i`=0. With `adv_i`=0, any other select pattern ends the current operation, and no data is driven in the following cycle.
- R3: For a read started at edge N, the addressed word is on `rdata_o` with `drive_o`=1 during the cycle after edge N, with no extra register stage. Whenever `drive_o` is 0, `rdata_o` is zero.
- R4: A write's data on `wdata_i` is sampled at the enabled edge after its address edge. Lane i is bits 9i+8..9i. It is stored only if bit i of `byte_en_i` was 1 at the address edge. Lanes whose enable bit is 0 keep their old contents.
- R5: A read issued directly after a write, including a read of the same word, returns the newly written data with no idle cycle between them.
- R6: With `adv_i`=1 at an enabled edge, an active operation continues: the read/write type and the upper address bits are kept, and the burst count rises by one, wrapping modulo 4. On a write beat, `byte_en_i` and the following data are taken afresh. An advance while no operation is active does nothing.
- R7: With `order_i`=0 the low two address bits are start XOR count. With `order_i`=1 they are (start + count) mod 4.
- R8: While `clk_en_i`=0 all registers hold and every synchronous input is ignored. A held read keeps driving the same word, and a pending write is not committed until the next enabled edge.
- R9: `oe_i`=0 forces `drive_o` to 0 at once, without changing any stored state.
- R10: While `sleep_i`=1 no operation starts or advances, the array is not written, `drive_o` is 0 and all state is held. After sleep is released the held burst continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock enable; 0 suspends the block |
| sel_a_i | input | 1 | Chip select, active high |
| sel_b_i | input | 1 | Chip select, active high |
| sel_n_i | input | 1 | Chip select, active low |
| adv_i | input | 1 | Continue the current burst |
| wr_i | input | 1 | 1 = write, 0 = read, sampled when an operation starts |
| byte_en_i | input | LANES | Per-lane write enables |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data, one cycle after its address |
| oe_i | input | 1 | Asynchronous output enable |
| order_i | input | 1 | Static burst order: 0 interleaved, 1 linear |
| sleep_i | input | 1 | Asynchronous power-down request |
| rdata_o | output | LANES*LANE_W | Flow-through read data, zero when not driven |
| drive_o | output | 1 | Output drive enable for the data pads |

## Verification
The assertions assume three things about the inputs. `order_i` changes only while no operation is active. `sleep_i` and `oe_i` change away from the rising edge. `wdata_i` is valid at the edge that captures a write beat. The bench meets these by driving every input at the falling edge and changing the burst order only after a deselect. Bench values that should be ignored are still placed on the data and address pins during suspended and sleeping cycles. These values target a word that the bench reads back later, so any leak shows up as a data mismatch.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_DESEL = 2'd1,
    OP_START = 2'd2,
    OP_ADV   = 2'd3
  } op_e;

  // low address bits of a burst beat
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       linear);
    return linear ? start + cnt : start ^ cnt;
  endfunction

endpackage

// File: rtl/nt_cmd_dec.sv
module nt_cmd_dec
  import nt_sram_pkg::*;
(
  input  logic clk_en_i,
  input  logic sleep_i,
  input  logic sel_a_i,
  input  logic sel_b_i,
  input  logic sel_n_i,
  input  logic adv_i,
  output op_e  op_o
);

  always_comb begin
    if (sleep_i || !clk_en_i)                 op_o = OP_HOLD;
    else if (adv_i)                           op_o = OP_ADV;
    else if (sel_a_i && sel_b_i && !sel_n_i)  op_o = OP_START;
    else                                      op_o = OP_DESEL;
  end

endmodule

// File: rtl/nt_burst_ctl.sv
module nt_burst_ctl
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic              linear_i,
  output logic              valid_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  be_o
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      wr_o    <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
      be_o    <= '0;
    end else begin
      unique case (op_i)
        OP_START: begin
          valid_o <= 1'b1;
          wr_o    <= wr_i;
          base_q  <= addr_i;
          cnt_q   <= '0;
          be_o    <= be_i;
        end
        OP_ADV: if (valid_o) begin
          cnt_q <= cnt_q + 2'd1;
          be_o  <= be_i;
        end
        OP_DESEL: valid_o <= 1'b0;
        OP_HOLD:  ;
      endcase
    end
  end

  assign addr_o = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, linear_i)};

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_START) |=> valid_o);

  p_adv_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADV && valid_o) |=> (cnt_q == $past(cnt_q) + 2'd1));

  p_upper_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADV) |=> (addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2])));

  p_hold_state_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_HOLD) |=> ($stable(valid_o) && $stable(base_q) && $stable(cnt_q)));

endmodule

// File: rtl/nt_wr_queue.sv
module nt_wr_queue #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              cur_valid_i,
  input  logic              cur_wr_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [LANES-1:0]  cur_be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic [LANES-1:0]  arr_we_o,
  output logic [ADDR_W-1:0] arr_waddr_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  output logic [DATA_W-1:0] rd_data_o
);

  logic              pend_valid_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [LANES-1:0]  pend_be_q;
  logic [DATA_W-1:0] pend_data_q;

  // capture write beat one enabled edge after its address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_valid_q <= 1'b0;
      pend_addr_q  <= '0;
      pend_be_q    <= '0;
      pend_data_q  <= '0;
    end else if (go_i) begin
      pend_valid_q <= cur_valid_i && cur_wr_i;
      if (cur_valid_i && cur_wr_i) begin
        pend_addr_q <= cur_addr_i;
        pend_be_q   <= cur_be_i;
        pend_data_q <= wdata_i;
      end
    end
  end

  assign arr_we_o    = (go_i && pend_valid_q) ? pend_be_q : '0;
  assign arr_waddr_o = pend_addr_q;
  assign arr_wdata_o = pend_data_q;

  logic addr_hit;
  assign addr_hit = pend_valid_q && (pend_addr_q == cur_addr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_byp
    assign rd_data_o[l*LANE_W +: LANE_W] = (addr_hit && pend_be_q[l])
        ? pend_data_q[l*LANE_W +: LANE_W] : arr_rdata_i[l*LANE_W +: LANE_W];
  end

  p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && cur_valid_i && cur_wr_i) |=> pend_valid_q);

  p_pend_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go_i |=> ($stable(pend_valid_q) && $stable(pend_data_q) && $stable(pend_addr_q)));

endmodule

// File: rtl/nt_array.sv
module nt_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic [LANES-1:0]  we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end
    assign rdata_o[l*LANE_W +: LANE_W] = mem[raddr_i];
  end

endmodule

// File: rtl/nt_sram_fe.sv
module nt_sram_fe
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,   // 4 for the 36-bit width
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              sel_a_i,
  input  logic              sel_b_i,
  input  logic              sel_n_i,
  input  logic              adv_i,
  input  logic              wr_i,
  input  logic [LANES-1:0]  byte_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              oe_i,
  input  logic              order_i,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);

  op_e               op;
  logic              cur_valid, cur_wr;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  cur_be;
  logic [LANES-1:0]  arr_we;
  logic [ADDR_W-1:0] arr_waddr;
  logic [DATA_W-1:0] arr_wdata, arr_rdata, byp_data;

  nt_cmd_dec u_dec (
    .clk_en_i (clk_en_i),
    .sleep_i  (sleep_i),
    .sel_a_i  (sel_a_i),
    .sel_b_i  (sel_b_i),
    .sel_n_i  (sel_n_i),
    .adv_i    (adv_i),
    .op_o     (op)
  );

  nt_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .be_i     (byte_en_i),
    .linear_i (order_i),
    .valid_o  (cur_valid),
    .wr_o     (cur_wr),
    .addr_o   (cur_addr),
    .be_o     (cur_be)
  );

  nt_wr_queue #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (op != OP_HOLD),
    .cur_valid_i (cur_valid),
    .cur_wr_i    (cur_wr),
    .cur_addr_i  (cur_addr),
    .cur_be_i    (cur_be),
    .wdata_i     (wdata_i),
    .arr_rdata_i (arr_rdata),
    .arr_we_o    (arr_we),
    .arr_waddr_o (arr_waddr),
    .arr_wdata_o (arr_wdata),
    .rd_data_o   (byp_data)
  );

  nt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i   (clk_i),
    .we_i    (arr_we),
    .waddr_i (arr_waddr),
    .wdata_i (arr_wdata),
    .raddr_i (cur_addr),
    .rdata_o (arr_rdata)
  );

  // flow-through: no register between array and pads
  assign drive_o = oe_i && !sleep_i && cur_valid && !cur_wr;
  assign rdata_o = drive_o ? byp_data : '0;

  p_sleep_no_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (arr_we == '0));

  p_suspend_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |-> (arr_we == '0));

  p_desel_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_DESEL) |=> !drive_o);

endmodule

// File: tb/tb_nt_sram_fe.sv
module tb_nt_sram_fe;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int LN = 2;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam logic [DW-1:0] JUNK  = 18'h3FFFF;
  localparam logic [AW-1:0] JADDR = 6'h10;

  typedef enum int {K_START, K_ADV, K_DESEL, K_SUSP, K_SLEEP} kind_e;
  typedef struct {
    logic          drv;
    logic [DW-1:0] data;
    string         tag;
  } item_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          clk_en_i = 1'b1;
  logic          sel_a_i = 1'b0, sel_b_i = 1'b0, sel_n_i = 1'b1;
  logic          adv_i = 1'b0, wr_i = 1'b0;
  logic [LN-1:0] byte_en_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          oe_i = 1'b1, order_i = 1'b0, sleep_i = 1'b0;
  logic [DW-1:0] rdata_o;
  logic          drive_o;

  nt_sram_fe #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
    .clk_i, .rst_ni, .clk_en_i, .sel_a_i, .sel_b_i, .sel_n_i, .adv_i, .wr_i,
    .byte_en_i, .addr_i, .wdata_i, .oe_i, .order_i, .sleep_i, .rdata_o, .drive_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  item_t sb_q[$];

  // reference model state
  logic [DW-1:0] ref_mem [1 << AW];
  logic          m_valid = 0, m_wr = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic [DW-1:0] m_wd = '0;

  function automatic logic [AW-1:0] m_eff();
    logic [1:0] lo;
    lo = order_i ? m_base[1:0] + m_cnt : m_base[1:0] ^ m_cnt;
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic step(input kind_e k, input logic [AW-1:0] a, input logic w,
                      input logic [LN-1:0] be, input logic [DW-1:0] d,
                      input logic oe, input logic [2:0] sel, input string tag);
    item_t it;
    logic [AW-1:0] ea;
    @(negedge clk_i);
    clk_en_i = (k != K_SUSP);
    sleep_i  = (k == K_SLEEP);
    oe_i     = oe;
    {sel_a_i, sel_b_i, sel_n_i} = sel;
    adv_i    = (k == K_ADV);
    wr_i     = w;
    addr_i   = a;
    byte_en_i = be;
    wdata_i  = (k != K_SUSP && k != K_SLEEP && m_valid && m_wr) ? m_wd : JUNK;
    case (k)
      K_START: begin m_valid = 1; m_wr = w; m_base = a; m_cnt = 0; end
      K_ADV:   if (m_valid) m_cnt = m_cnt + 2'd1;
      K_DESEL: m_valid = 0;
      default: ;
    endcase
    if ((k == K_START || k == K_ADV) && m_valid && m_wr) begin
      m_wd = d;
      ea = m_eff();
      for (int l = 0; l < LN; l++)
        if (be[l]) ref_mem[ea][l*LW +: LW] = d[l*LW +: LW];
    end
    it.drv  = (k != K_SLEEP) && oe && m_valid && !m_wr;
    it.data = it.drv ? ref_mem[m_eff()] : '0;
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  task automatic s_wr(input logic [AW-1:0] a, input logic [LN-1:0] be,
                      input logic [DW-1:0] d, input string tag);
    step(K_START, a, 1'b1, be, d, 1'b1, 3'b110, tag);
  endtask
  task automatic s_rd(input logic [AW-1:0] a, input logic oe, input string tag);
    step(K_START, a, 1'b0, 2'b11, JUNK, oe, 3'b110, tag);
  endtask
  task automatic s_adv(input logic [LN-1:0] be, input logic [DW-1:0] d, input string tag);
    step(K_ADV, 6'h3F, 1'b1, be, d, 1'b1, 3'b000, tag);
  endtask
  task automatic s_desel(input logic [2:0] sel, input string tag);
    step(K_DESEL, JADDR, 1'b1, 2'b11, JUNK, 1'b1, sel, tag);
  endtask
  task automatic s_susp(input string tag);
    step(K_SUSP, JADDR, 1'b1, 2'b11, JUNK, 1'b1, 3'b110, tag);
  endtask
  task automatic s_sleep(input string tag);
    step(K_SLEEP, JADDR, 1'b1, 2'b11, JUNK, 1'b1, 3'b110, tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (drive_o !== it.drv || rdata_o !== it.data) begin
          errors++;
          $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                   it.tag, drive_o, rdata_o, it.drv, it.data);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      errors++;
      $display("FAIL R3: watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #(CLK_PERIOD/4);
    checks++;
    if (drive_o !== 1'b0 || rdata_o !== '0) begin
      errors++;
      $display("FAIL R1: drive=%0b data=%h expected drive=0 data=0", drive_o, rdata_o);
    end

    // interleaved write burst with wraparound: 12,13,10,11
    s_wr(6'h12, 2'b11, 18'h11111, "R6");
    s_adv(2'b11, 18'h22222, "R7");
    s_adv(2'b11, 18'h33333, "R7");
    s_adv(2'b11, 18'h04444, "R6");
    // interleaved read burst: 11,10,13,12 then wrap to 11
    s_rd(6'h11, 1'b1, "R3");
    s_adv(2'b11, JUNK, "R7");
    s_adv(2'b11, JUNK, "R7");
    s_adv(2'b11, JUNK, "R7");
    s_adv(2'b11, JUNK, "R6");
    // back-to-back read/write with bypass
    s_wr(6'h20, 2'b11, 18'h0ABCD, "R4");
    s_rd(6'h20, 1'b1, "R5");
    s_wr(6'h21, 2'b11, 18'h12345, "R5");
    s_rd(6'h21, 1'b1, "R5");
    s_rd(6'h20, 1'b1, "R3");
    // byte-masked writes
    s_wr(6'h20, 2'b01, 18'h3FFFF, "R4");
    s_rd(6'h20, 1'b1, "R4");
    s_wr(6'h21, 2'b10, 18'h00000, "R4");
    s_wr(6'h21, 2'b00, 18'h3FFFF, "R4");
    s_rd(6'h21, 1'b1, "R4");
    s_wr(6'h24, 2'b10, 18'h2AAAA, "R4");
    s_adv(2'b01, 18'h15555, "R6");
    s_rd(6'h24, 1'b1, "R4");
    s_adv(2'b11, JUNK, "R4");
    // suspend during a read burst
    s_rd(6'h12, 1'b1, "R8");
    s_susp("R8");
    s_susp("R8");
    s_adv(2'b11, JUNK, "R8");
    // suspend between write address and data
    s_wr(6'h30, 2'b11, 18'h2468A, "R8");
    s_susp("R8");
    s_rd(6'h30, 1'b1, "R8");
    s_susp("R8");
    s_rd(6'h30, 1'b1, "R8");
    // output enable
    s_rd(6'h13, 1'b0, "R9");
    s_rd(6'h13, 1'b1, "R9");
    // sleep in a read burst, then resume
    s_rd(6'h10, 1'b1, "R10");
    s_sleep("R10");
    s_sleep("R10");
    s_adv(2'b11, JUNK, "R10");
    // sleep between write address and data
    s_wr(6'h28, 2'b11, 18'h13579, "R10");
    s_sleep("R10");
    s_rd(6'h28, 1'b1, "R10");
    s_rd(6'h10, 1'b1, "R10");
    // chip selects
    s_rd(6'h20, 1'b1, "R2");
    s_desel(3'b010, "R2");
    s_adv(2'b11, 18'h00000, "R6");
    s_desel(3'b100, "R2");
    s_desel(3'b111, "R2");
    s_rd(6'h21, 1'b1, "R2");
    s_desel(3'b000, "R2");
    order_i = 1'b1;
    // linear read burst: 12,13,10,11
    s_rd(6'h12, 1'b1, "R7");
    s_adv(2'b11, JUNK, "R7");
    s_adv(2'b11, JUNK, "R7");
    s_adv(2'b11, JUNK, "R7");
    // linear write burst: 23,20,21,22
    s_wr(6'h23, 2'b11, 18'h00101, "R7");
    s_adv(2'b11, 18'h00202, "R7");
    s_adv(2'b11, 18'h00303, "R7");
    s_adv(2'b11, 18'h00404, "R7");
    // linear read burst: 21,22,23,20
    s_rd(6'h21, 1'b1, "R7");
    s_adv(2'b11, JUNK, "R7");
    s_adv(2'b11, JUNK, "R7");
    s_adv(2'b11, JUNK, "R6");
    s_desel(3'b011, "R2");
    s_desel(3'b110 ^ 3'b001, "R2");

    repeat (3) @(negedge clk_i);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R3: pending=%0d expected=0", sb_q.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule